// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. In a load cycle it takes the whole external address. In each later advance cycle it keeps the upper address bits and steps only the two lowest bits. Those two bits follow one of two orders, picked by a mode input: an exclusive-or order, in which the beat index is XORed into the starting low bits, or a linear order, in which the beat index is added to them modulo four. Either way the burst stays inside the aligned group of four words it started in. It comes back to the starting word after four advances and then runs the same sequence again.

The memory controller drives a single load/advance strobe and a clock enable. The block does not care whether a burst is a read, a write or a continued deselect, so every advance cycle steps it. When the clock enable is low the whole block is frozen. The mode input is meant to be static. Tying it high, which is the usual default strap, selects the exclusive-or order. The output comes straight from a register and is valid in the cycle after the edge that updated it.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, burst_addr becomes all zeros after that edge, and the beat count restarts.
- R2: At an edge with clk_en=1 and adv_ld=0 (load), burst_addr takes ext_addr after the edge, and the next advance is beat 1 of a new burst whose start is ext_addr[1:0].
- R3: At an edge with clk_en=0, burst_addr keeps its value and the beat count does not move, whatever adv_ld, ext_addr and seq_mode are.
- R4: At an edge with clk_en=1 and adv_ld=1 (advance), burst_addr[ADDR_W-1:2] keeps its value, and ext_addr has no effect on burst_addr.
- R5: With seq_mode=1 (interleaved), the k-th advance after a load gives burst_addr[1:0] = start XOR (k mod 4).
- R6: With seq_mode=0 (linear), the k-th advance after a load gives burst_addr[1:0] = (start + k) mod 4.
- R7: The fourth advance after a load puts burst_addr back to the loaded address, and the fifth advance matches the first.
- R8: A load in the middle of a burst drops the old beat count, so the next advance is beat 1 counted from the newly loaded start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | 1 = act at this edge, 0 = hold all state |
| adv_ld | input | 1 | 0 = load ext_addr, 1 = advance to the next beat |
| ext_addr | input | ADDR_W | External address, sampled on a load |
| seq_mode | input | 1 | 1 = interleaved (XOR) order, 0 = linear order |
| burst_addr | output | ADDR_W | Address of the current beat |

## Verification
A corrupted beat counter or a corrupted captured start shows up on burst_addr[1:0] at the very next advance edge: the wrong word inside the group is addressed one cycle later. A fault in holding the upper bits shows up as a jump to another group on the first advance. Without a correct count the return to the start after four beats does not happen, so every burst is run at least five beats, in both orders, from all four start positions. Stalls and loads in the middle of a burst are mixed in so that a counter that slips or fails to clear becomes visible within one beat.

// File: rtl/bseq_pkg.sv
// Package: shared widths and types for the burst address sequencer.
// Assumes the burst is always four beats, so two low address bits are stepped.
package bseq_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_order.sv
// Module: bseq_order
// Turns a burst start position and a beat index into the low address bits
// of that beat. Purely combinational.
// Assumes: the index is already reduced modulo the burst length.
module bseq_order
    import bseq_pkg::*;
(
    input  beat_t  start_pos,
    input  beat_t  beat_idx,
    input  order_e order_sel,
    output beat_t  beat_pos
);
    beat_t xor_pos;
    beat_t lin_pos;

    // Build both orders, then let the mode pick one.
    always_comb begin
        xor_pos  = start_pos ^ beat_idx;
        lin_pos  = start_pos + beat_idx;
        beat_pos = (order_sel == ORD_INTERLEAVE) ? xor_pos : lin_pos;
    end
endmodule

// File: rtl/bseq_beat_cnt.sv
// Module: bseq_beat_cnt
// Stores the start position of the burst and counts its beats.
// Gives out the index the next advance will use.
// Assumes: synchronous active-low reset; clk_en freezes all state.
module bseq_beat_cnt
    import bseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clk_en,
    input  logic  adv_ld,
    input  beat_t load_pos,
    output beat_t start_pos,
    output beat_t next_idx
);
    beat_t start_q;
    beat_t idx_q;

    // Index of the beat after the current one; wraps at the burst length.
    always_comb next_idx = idx_q + beat_t'(1);

    // Take the start on a load, move the index on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            idx_q   <= '0;
        end else if (clk_en) begin
            if (!adv_ld) begin
                start_q <= load_pos;
                idx_q   <= '0;
            end else begin
                idx_q   <= next_idx;
            end
        end
    end

    assign start_pos = start_q;
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Produces a registered burst address. A load takes the external address;
// an advance keeps the upper bits and moves the low two bits in the
// interleaved or the linear order chosen by seq_mode.
// Assumes: seq_mode is static during a burst; ADDR_W is larger than 2.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              seq_mode,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    beat_t  start_pos;
    beat_t  next_idx;
    beat_t  next_pos;
    order_e order_sel;
    logic [ADDR_W-1:0] addr_q;

    // Turn the mode pin into the order type.
    always_comb order_sel = order_e'(seq_mode);

    bseq_beat_cnt cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv_ld    (adv_ld),
        .load_pos  (ext_addr[BEAT_W-1:0]),
        .start_pos (start_pos),
        .next_idx  (next_idx)
    );

    bseq_order ord_i (
        .start_pos (start_pos),
        .beat_idx  (next_idx),
        .order_sel (order_sel),
        .beat_pos  (next_pos)
    );

    generate
        if (UPPER_W > 0) begin : g_upper
            // Output register: a load replaces it, an advance changes only the low bits.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    addr_q <= '0;
                else if (clk_en) begin
                    if (!adv_ld)
                        addr_q <= ext_addr;
                    else
                        addr_q <= {addr_q[ADDR_W-1:BEAT_W], next_pos};
                end
            end
        end else begin : g_narrow
            // Output register when the address is exactly the beat field.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    addr_q <= '0;
                else if (clk_en)
                    addr_q <= adv_ld ? next_pos : ext_addr;
            end
        end
    endgenerate

    assign burst_addr = addr_q;
endmodule

// File: rtl/bseq_checker.sv
// Module: bseq_checker
// Property checker for burst_addr_seq, looking only at its ports.
// It keeps its own copy of the burst start and the beat count.
module bseq_checker #(
    parameter int ADDR_W = 18
)(
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              seq_mode,
    input logic [ADDR_W-1:0] burst_addr
);
    logic [1:0] s_start;
    logic [1:0] s_cnt;

    // Shadow of the burst start and the beat count, taken from the inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_start <= '0;
            s_cnt   <= '0;
        end else if (clk_en) begin
            if (!adv_ld) begin
                s_start <= ext_addr[1:0];
                s_cnt   <= '0;
            end else begin
                s_cnt   <= s_cnt + 2'd1;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> burst_addr == '0);

    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld) |=> burst_addr == $past(ext_addr));

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(burst_addr));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld) |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));

    a_r5_xor_order: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && seq_mode) |=>
            burst_addr[1:0] == $past(s_start ^ (s_cnt + 2'd1)));

    a_r6_linear_order: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && !seq_mode) |=>
            burst_addr[1:0] == $past(s_start + s_cnt + 2'd1));

    a_r7_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && s_cnt == 2'd3) |=> burst_addr[1:0] == $past(s_start));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .adv_ld     (adv_ld),
    .ext_addr   (ext_addr),
    .seq_mode   (seq_mode),
    .burst_addr (burst_addr)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver sets inputs on the falling edge and queues the
// expected address; the monitor checks it 1 ns after the next rising edge.
module burst_addr_seq_tb_top;
    localparam int AW = 18;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic          clk_en   = 1'b0;
    logic          adv_ld   = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          seq_mode = 1'b1;
    logic [AW-1:0] burst_addr;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference model state
    logic [AW-1:0] m_addr  = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_cnt   = '0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
        .ext_addr(ext_addr), .seq_mode(seq_mode), .burst_addr(burst_addr)
    );

    // Driver: apply one cycle of inputs and queue the expected result.
    task automatic drive(input logic rs, input logic en, input logic adv,
                         input logic [AW-1:0] a, input logic md, input string tag);
        @(negedge clk);
        rst_n = rs; clk_en = en; adv_ld = adv; ext_addr = a; seq_mode = md;
        if (!rs) begin
            m_addr = '0; m_start = '0; m_cnt = '0;
        end else if (en) begin
            if (!adv) begin
                m_addr = a; m_start = a[1:0]; m_cnt = '0;
            end else begin
                m_cnt = m_cnt + 2'd1;
                m_addr[1:0] = md ? (m_start ^ m_cnt) : (m_start + m_cnt);
            end
        end
        exp_q.push_back(m_addr);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the output after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (burst_addr !== e) begin
                n_fail++;
                $display("FAIL %s: burst_addr=%05h expected=%05h", t, burst_addr, e);
            end
        end
    end

    initial begin
        // R1: reset state
        drive(1'b0, 1'b1, 1'b0, 18'h2ABCD, 1'b1, "R1");
        drive(1'b0, 1'b0, 1'b1, 18'h1F0F3, 1'b1, "R1");

        // R5/R7: interleaved bursts from every start, six advances each
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b1, 1'b0, {16'h5A3C, 2'(s)}, 1'b1, "R2");
            for (int k = 1; k <= 6; k++)
                drive(1'b1, 1'b1, 1'b1, 18'h3FFFF ^ AW'(k * 37), 1'b1,
                      (k == 4 || k == 5) ? "R7" : "R5");
        end

        // R6/R7: linear bursts from every start
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b1, 1'b0, {16'hC381, 2'(s)}, 1'b0, "R2");
            for (int k = 1; k <= 6; k++)
                drive(1'b1, 1'b1, 1'b1, AW'(k * 911), 1'b0,
                      (k == 4 || k == 5) ? "R7" : "R6");
        end

        // R3: stalls mid-burst with other inputs moving, then resume
        drive(1'b1, 1'b1, 1'b0, 18'h0F0F2, 1'b0, "R2");
        drive(1'b1, 1'b1, 1'b1, 18'h00000, 1'b0, "R6");
        drive(1'b1, 1'b0, 1'b0, 18'h3FFFF, 1'b0, "R3");
        drive(1'b1, 1'b0, 1'b1, 18'h12345, 1'b0, "R3");
        drive(1'b1, 1'b1, 1'b1, 18'h3FFFF, 1'b0, "R3");

        // R4: advance with wild ext_addr keeps the upper bits
        drive(1'b1, 1'b1, 1'b0, 18'h00001, 1'b1, "R2");
        drive(1'b1, 1'b1, 1'b1, 18'h3FFFE, 1'b1, "R4");
        drive(1'b1, 1'b1, 1'b1, 18'h2AAAA, 1'b1, "R4");

        // R8: load in the middle of a burst restarts the count
        drive(1'b1, 1'b1, 1'b0, 18'h10003, 1'b1, "R8");
        drive(1'b1, 1'b1, 1'b1, 18'h00000, 1'b1, "R8");
        drive(1'b1, 1'b1, 1'b1, 18'h00000, 1'b1, "R8");

        // R1: reset in the middle of a burst, then advance from zero
        drive(1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, "R1");
        drive(1'b1, 1'b1, 1'b1, 18'h3FFFF, 1'b0, "R1");

        drive(1'b1, 1'b0, 1'b1, 18'h00000, 1'b0, "R3");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule